// File: doc/BRIEF.md
# Radar Echo Strength Detector

This block takes a stream of signed 8-bit radar echo samples, one per enabled clock, and reports whether a strong reflection is present. Each sample first passes through a four-point moving-average smoother that suppresses sample-to-sample noise. The smoothed value is turned into a magnitude, and a peak-holding envelope follows it. The envelope jumps up at once to a larger magnitude and otherwise falls by one count per enabled cycle, stopping at zero.

The envelope is compared with a fixed detection level. A single 8-bit result word carries the upper seven envelope bits and a detect flag. Processing advances only while the enable input is high. A synchronous active-low reset empties the smoother history, the envelope and the result.

Each enabled cycle the envelope tracker picks one of three named update states. ENV_ATTACK loads the new magnitude when it is larger than the decayed envelope. ENV_DECAY steps the envelope down by one. ENV_FLOOR holds it at zero once it has run out. The choice is made afresh every enabled cycle, so any state can move to any other on the next sample: a larger magnitude selects ENV_ATTACK, a smaller one with a non-zero envelope selects ENV_DECAY, and a zero envelope with no larger magnitude selects ENV_FLOOR.

Top module: `echo_detector`

## Requirements
- R1: On each rising clock edge with en high, one sample is taken from sample_in and read as signed two's complement (0x80 is -128, 0x7F is +127).
- R2: The smoothed value is the sum of the current sample and the three samples taken before it, shifted right by two with sign extension (rounding toward minus infinity).
- R3: The magnitude is the absolute value of the smoothed value. A smoothed value of -128 gives 127, so the magnitude never exceeds 127.
- R4: Each enabled cycle the new envelope is the larger of the magnitude and (previous envelope minus one). The envelope never goes below zero and never wraps.
- R5: result_out bits [7:1] carry envelope bits [7:1].
- R6: result_out bit 0 is 1 only when the full 8-bit envelope is strictly greater than DETECT_LEVEL (default 96). An envelope equal to the level gives 0.
- R7: A sample taken at enabled edge n first affects result_out right after enabled edge n+2. That is three enabled edges, counting its own.
- R8: While en is low, the sample history, smoothed value, envelope and result_out all hold. Once en returns high, processing resumes as though the idle cycles never happened.
- R9: A clock edge with rst_n low clears the sample history, smoothed value, envelope and result_out to zero, whatever the level of en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advances the pipeline when high |
| sample_in | input | 8 | Signed radar echo sample |
| result_out | output | 8 | [7:1] envelope upper bits, [0] detect flag |

## Verification
A corrupted history word in the smoother changes the result word two enabled cycles later, and the error persists for up to three further samples. A wrong envelope update shows at the very next enabled edge. Because the envelope decays by only one count per sample, an error there can stay visible for many cycles. A decay that wraps below zero shows at once as a near-full result word with the flag set. A stage that keeps running while en is low shows as a result word that drifts during a stall.

// File: rtl/echo_pkg.sv
package echo_pkg;

    // Update choice made by the envelope tracker on every enabled cycle
    typedef enum logic [1:0] {
        ENV_FLOOR  = 2'd0,
        ENV_DECAY  = 2'd1,
        ENV_ATTACK = 2'd2
    } env_mode_e;

endpackage

// File: rtl/echo_fir.sv
module echo_fir #(
    parameter int W    = 8,
    parameter int TAPS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] sample_i,
    output logic signed [W-1:0] filt_o
);
    localparam int SHIFT = $clog2(TAPS);
    localparam int SUM_W = W + SHIFT;
    localparam int HIST  = TAPS - 1;

    logic signed [W-1:0]     hist_q [HIST];
    logic signed [SUM_W-1:0] sum;
    logic signed [W-1:0]     filt_q;

    // Moving sum over the current sample and the stored history
    always_comb begin
        sum = SUM_W'(sample_i);
        for (int i = 0; i < HIST; i++) begin
            sum = sum + SUM_W'(hist_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST; i++) begin
                hist_q[i] <= '0;
            end
            filt_q <= '0;
        end else if (en) begin
            hist_q[0] <= sample_i;
            for (int i = 1; i < HIST; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
            filt_q <= W'(sum >>> SHIFT);
        end
    end

    assign filt_o = filt_q;

    // R8
    fir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(filt_q));

endmodule

// File: rtl/echo_env.sv
module echo_env
    import echo_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] filt_i,
    output logic        [W-1:0] env_o
);
    localparam logic        [W-1:0] MAG_MAX  = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mag;
    logic [W-1:0] decayed;
    logic [W-1:0] env_q;
    logic [W-1:0] env_n;
    env_mode_e    mode;

    // Saturating absolute value
    always_comb begin
        if (filt_i == MOST_NEG) begin
            mag = MAG_MAX;
        end else if (filt_i[W-1]) begin
            mag = W'(-filt_i);
        end else begin
            mag = filt_i;
        end
    end

    // Pick the update state for this cycle
    always_comb begin
        decayed = (env_q == '0) ? '0 : env_q - W'(1);
        if (mag > decayed) begin
            mode = ENV_ATTACK;
        end else if (env_q == '0) begin
            mode = ENV_FLOOR;
        end else begin
            mode = ENV_DECAY;
        end
    end

    always_comb begin
        unique case (mode)
            ENV_ATTACK: env_n = mag;
            ENV_DECAY:  env_n = env_q - W'(1);
            ENV_FLOOR:  env_n = '0;
            default:    env_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            env_q <= '0;
        end else if (en) begin
            env_q <= env_n;
        end
    end

    assign env_o = env_q;

    // R4
    env_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ({1'b0, env_q} + (W+1)'(1)) >= {1'b0, $past(env_q)});

    // R3
    env_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        env_q <= MAG_MAX);

    // R8
    env_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(env_q));

endmodule

// File: rtl/echo_pack.sv
module echo_pack #(
    parameter int W      = 8,
    parameter int THRESH = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] env_i,
    output logic [W-1:0] out_o
);
    localparam logic [W-1:0] THRESH_V  = W'(THRESH);
    localparam logic [W-2:0] THRESH_HI = (W-1)'((THRESH + 1) >> 1);

    logic         over;
    logic [W-1:0] out_q;

    assign over = env_i > THRESH_V;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (en) begin
            out_q <= {env_i[W-1:1], over};
        end
    end

    assign out_o = out_q;

    // R6
    flag_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q[0] |-> out_q[W-1:1] >= THRESH_HI);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(out_q));

endmodule

// File: rtl/echo_detector.sv
module echo_detector #(
    parameter int SAMPLE_W     = 8,
    parameter int TAP_COUNT    = 4,
    parameter int DETECT_LEVEL = 96
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [SAMPLE_W-1:0] result_out
);
    logic signed [SAMPLE_W-1:0] smooth;
    logic        [SAMPLE_W-1:0] envelope;

    echo_fir #(.W(SAMPLE_W), .TAPS(TAP_COUNT)) u_fir (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sample_i (sample_in),
        .filt_o   (smooth)
    );

    echo_env #(.W(SAMPLE_W)) u_env (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .filt_i (smooth),
        .env_o  (envelope)
    );

    echo_pack #(.W(SAMPLE_W), .THRESH(DETECT_LEVEL)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .env_i (envelope),
        .out_o (result_out)
    );

endmodule

// File: tb/sim_echo_detector.sv
`timescale 1ns/100ps
module sim_echo_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] sample_in = 8'h00;
    logic [7:0] result_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    echo_detector u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .sample_in  (sample_in),
        .result_out (result_out)
    );

    // {sample, expected result after the edge that takes the sample}
    localparam logic [15:0] VEC [18] = '{
        {8'h64, 8'd0},   {8'h64, 8'd0},   {8'h64, 8'd24},  {8'h64, 8'd50},
        {8'h64, 8'd74},  {8'h00, 8'd101}, {8'h00, 8'd101}, {8'h00, 8'd99},
        {8'h00, 8'd99},  {8'h00, 8'd97},  {8'h00, 8'd96},  {8'h00, 8'd94},
        {8'h80, 8'd94},  {8'h80, 8'd92},  {8'h80, 8'd92},  {8'h80, 8'd90},
        {8'h80, 8'd96},  {8'h80, 8'd127}
    };

    task automatic tick(input logic [7:0] s, input logic e);
        sample_in = s;
        en = e;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        tick(8'h00, 1'b1);
        tick(8'h00, 1'b1);
        chk(result_out, 8'd0, "R9 reset state");
        rst_n = 1'b1;

        // Main sequence: rise, peak, decay, equal-threshold, saturation
        for (int i = 0; i < 18; i++) begin
            tick(VEC[i][15:8], 1'b1);
            chk(result_out, VEC[i][7:0],
                $sformatf("R1 R2 R3 R4 R5 R6 R7 row %0d", i));
        end

        // R8: stall with changing input, nothing moves
        for (int i = 0; i < 5; i++) begin
            tick(8'h32 + 8'(i), 1'b0);
            chk(result_out, 8'd127, "R8 stall hold");
        end
        // R8: resume as if no gap (history still holds three -128 samples)
        tick(8'h00, 1'b1); chk(result_out, 8'd127, "R8 resume 1");
        tick(8'h00, 1'b1); chk(result_out, 8'd127, "R8 resume 2");
        tick(8'h00, 1'b1); chk(result_out, 8'd127, "R8 resume 3");
        tick(8'h00, 1'b1); chk(result_out, 8'd125, "R8 resume 4");

        // R9: reset with en low clears everything, including history
        tick(8'h80, 1'b1);
        tick(8'h80, 1'b1);
        rst_n = 1'b0;
        tick(8'h80, 1'b0);
        chk(result_out, 8'd0, "R9 reset over enable");
        rst_n = 1'b1;
        tick(8'h64, 1'b1); chk(result_out, 8'd0, "R9 cleared path a");
        tick(8'h00, 1'b1); chk(result_out, 8'd0, "R9 cleared path b");
        tick(8'h00, 1'b1); chk(result_out, 8'd24, "R9 R2 cleared history");

        // R4: long run of zeros, envelope settles at zero without wrap
        for (int i = 0; i < 40; i++) begin
            tick(8'h00, 1'b1);
            if (i >= 35) chk(result_out, 8'd0, "R4 floor at zero");
        end

        done = 1'b1;
        summary();
    end

endmodule